// File: doc/BRIEF.md
# Burst Line-Fill Cache

This block is a direct-mapped read cache that sits between a processor port and a synchronous memory port. Each of its sixteen lines holds four 32-bit long words under a single tag. The tag is built from the upper address bits together with the access function code, so supervisor and user accesses to the same address occupy separate entries. When a read misses, the block fetches the whole line as a four-beat burst and then answers the processor from the freshly filled line. The expectation is that the words following the one that missed will then hit without further memory traffic.

Writes always go through to memory as single accesses. A write to a resident word also updates the cached copy. A write that misses leaves the cache contents unchanged. A global enable input switches the cache off. While it is off, every access goes to memory as a single transfer and all lines are invalidated, so nothing stale can hit once the cache is switched back on. Because the line index comes from low address bits, two addresses that differ by a multiple of 256 bytes compete for the same line and evict each other.

Top module: `lfc_cache`

## Requirements
- R1: While reset is asserted, cpu_ack and mem_req are low. After reset every line is invalid, so the first read always misses.
- R2: A read miss with the cache enabled issues exactly four burst beats (mem_burst high). They run in order from word 0 to word 3 of the line, with mem_addr equal to the line base plus 4 times the beat number.
- R3: After the fill completes, the processor receives the word selected by address bits [3:2], equal to the memory contents, and no cpu_ack is given while the burst is in progress.
- R4: A read of any word of a resident line, with a matching tag, is acknowledged in the same cycle as the request and makes no memory access.
- R5: The tag includes the 3-bit function code. A read to a resident address with a different function code misses and refills the line.
- R6: Addresses that share bits [7:4] but differ in higher bits evict each other from the one line they share.
- R7: Every write reaches memory as one single (non-burst) access. The processor is acknowledged in the cycle in which memory acknowledges it.
- R8: A write that hits updates the cached word, so a later read of that word hits and returns the new data.
- R9: A write that misses does not allocate a line, so a later read of that address misses and bursts.
- R10: While cache_en is low, reads and writes are single memory accesses, no burst occurs, and read data comes straight from memory.
- R11: Lowering cache_en invalidates every line. After it is raised again, a previously resident line misses.
- R12: Once mem_req is raised, it stays high, with mem_addr, mem_we and mem_burst unchanged, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cache_en | input | 1 | Cache enable; low bypasses the cache and invalidates all lines |
| cpu_req | input | 1 | Processor access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_fc | input | 3 | Function code (supervisor/user and space), part of the tag |
| cpu_addr | input | 32 | Byte address of a long word (bits [1:0] ignored) |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Access complete; read data valid in this cycle |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_burst | output | 1 | Current beat belongs to a four-beat line fill |
| mem_we | output | 1 | Memory write |
| mem_fc | output | 3 | Function code forwarded to memory |
| mem_addr | output | 32 | Memory address of the current beat or single access |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepted or returned the current beat |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The properties assume the processor keeps cpu_addr, cpu_fc, cpu_we and cpu_wdata steady from the request until the acknowledge and drops cpu_req right after it. They also assume cache_en only changes while no access is in flight, and that memory eventually answers every request. The stimulus task follows these rules. It raises the request on a falling edge, holds every field until it sees the acknowledge, and withdraws the request just after the next rising edge. The enable is toggled only between accesses. Part of the run uses a memory that acknowledges every other cycle, so the hold-until-acknowledge rule is exercised with real stalls.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_RESP   = 2'd2,
    ST_SINGLE = 2'd3
  } lfc_state_e;

endpackage

// File: rtl/lfc_tag_store.sv
module lfc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 27,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag
);

  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  // valid bits: cleared on flush, set by a completed fill
  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (upd_en) begin
      valid_d[lk_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // tag storage has no reset; the valid bit guards it
  for (genvar g = 0; g < LINES; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (upd_en && (lk_idx == IDX_W'(g))) begin
        tag_q[g] <= upd_tag;
      end
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/lfc_data_store.sv
module lfc_data_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int ENT   = LINES * WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem_q [ENT];
  logic [IDX_W+OFF_W-1:0] wr_sel;

  assign wr_sel = {idx, wr_word};

  for (genvar e = 0; e < ENT; e++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == (IDX_W+OFF_W)'(e))) begin
        mem_q[e] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[{idx, rd_word}];

endmodule

// File: rtl/lfc_ctrl.sv
module lfc_ctrl
  import lfc_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cache_en,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic             lk_hit,
  input  logic             mem_ack,
  output logic [OFF_W-1:0] beat,
  output logic             tag_upd,
  output logic             fill_wr,
  output logic             hit_wr,
  output logic             cpu_ack,
  output logic             rd_from_mem,
  output logic             mem_req,
  output logic             mem_burst,
  output logic             mem_we
);

  lfc_state_e       state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic             beat_en;

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    beat_en     = 1'b0;
    tag_upd     = 1'b0;
    fill_wr     = 1'b0;
    hit_wr      = 1'b0;
    cpu_ack     = 1'b0;
    rd_from_mem = 1'b0;
    mem_req     = 1'b0;
    mem_burst   = 1'b0;
    mem_we      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cache_en && !cpu_we) begin
            if (lk_hit) begin
              cpu_ack = 1'b1;
            end else begin
              state_d = ST_FILL;
              beat_d  = '0;
              beat_en = 1'b1;
            end
          end else begin
            state_d = ST_SINGLE;
          end
        end
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_burst = 1'b1;
        if (mem_ack) begin
          fill_wr = 1'b1;
          beat_d  = beat_q + 1'b1;
          beat_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            tag_upd = 1'b1;
            state_d = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        cpu_ack = 1'b1;
        state_d = ST_IDLE;
      end
      ST_SINGLE: begin
        mem_req     = 1'b1;
        mem_we      = cpu_we;
        rd_from_mem = 1'b1;
        if (mem_ack) begin
          cpu_ack = 1'b1;
          hit_wr  = cpu_we && cache_en && lk_hit;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) begin
        beat_q <= beat_d;
      end
    end
  end

  assign beat = beat_q;

endmodule

// File: rtl/lfc_cache.sv
module lfc_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FC_W   = 3,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int LO_W   = BYTE_W + OFF_W + IDX_W,
  localparam int TAG_W  = FC_W + ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [FC_W-1:0]   cpu_fc,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_burst,
  output logic              mem_we,
  output logic [FC_W-1:0]   mem_fc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  word;
  logic [TAG_W-1:0]  tag;
  logic              lk_hit;
  logic [OFF_W-1:0]  beat;
  logic              tag_upd, fill_wr, hit_wr, rd_from_mem;
  logic [DATA_W-1:0] arr_rdata;
  logic              dw_en;
  logic [OFF_W-1:0]  dw_word;
  logic [DATA_W-1:0] dw_data;

  assign idx  = cpu_addr[BYTE_W+OFF_W +: IDX_W];
  assign word = cpu_addr[BYTE_W +: OFF_W];
  assign tag  = {cpu_fc, cpu_addr[ADDR_W-1:LO_W]};

  lfc_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .flush   (!cache_en),
    .lk_idx  (idx),
    .lk_tag  (tag),
    .lk_hit  (lk_hit),
    .upd_en  (tag_upd),
    .upd_tag (tag)
  );

  assign dw_en   = fill_wr || hit_wr;
  assign dw_word = fill_wr ? beat : word;
  assign dw_data = fill_wr ? mem_rdata : cpu_wdata;

  lfc_data_store #(
    .LINES  (LINES),
    .WORDS  (WORDS),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .idx     (idx),
    .rd_word (word),
    .rd_data (arr_rdata),
    .wr_en   (dw_en),
    .wr_word (dw_word),
    .wr_data (dw_data)
  );

  lfc_ctrl #(
    .WORDS (WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cache_en    (cache_en),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .lk_hit      (lk_hit),
    .mem_ack     (mem_ack),
    .beat        (beat),
    .tag_upd     (tag_upd),
    .fill_wr     (fill_wr),
    .hit_wr      (hit_wr),
    .cpu_ack     (cpu_ack),
    .rd_from_mem (rd_from_mem),
    .mem_req     (mem_req),
    .mem_burst   (mem_burst),
    .mem_we      (mem_we)
  );

  assign cpu_rdata = rd_from_mem ? mem_rdata : arr_rdata;
  assign mem_addr  = mem_burst ? {cpu_addr[ADDR_W-1:BYTE_W+OFF_W], beat, {BYTE_W{1'b0}}}
                               : cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign mem_fc    = cpu_fc;

endmodule

// File: rtl/lfc_cache_chk.sv
module lfc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              cache_en,
  input logic              cpu_req,
  input logic              cpu_ack,
  input logic              mem_req,
  input logic              mem_burst,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);

  // R7: writes never travel as part of a burst
  assert_write_single_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_req && mem_we) |-> !mem_burst);

  // R12: request and its attributes hold until memory answers
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_burst)));

  // R2: a burst starts at word 0
  assert_burst_start_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(mem_burst) |-> (mem_addr[BYTE_W +: OFF_W] == '0));

  // R2: accepted beats advance by one word until the last
  assert_beat_order_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_req && mem_burst && mem_ack && (mem_addr[BYTE_W +: OFF_W] != '1))
    |=> (mem_req && mem_burst
         && (mem_addr[BYTE_W +: OFF_W] == OFF_W'($past(mem_addr[BYTE_W +: OFF_W]) + 1'b1))));

  // R10: no line fill while the cache is switched off
  assert_off_no_burst_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_req && mem_burst) |-> cache_en);

  // R3: the processor is not answered in the middle of a fill
  assert_no_ack_in_fill_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_req && mem_burst) |-> !cpu_ack);

  // R4: an acknowledge only answers a pending request
  assert_ack_has_req_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    cpu_ack |-> cpu_req);

endmodule

bind lfc_cache lfc_cache_chk #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_q),
  .cache_en  (cache_en),
  .cpu_req   (cpu_req),
  .cpu_ack   (cpu_ack),
  .mem_req   (mem_req),
  .mem_burst (mem_burst),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr)
);

// File: tb/sim_lfc_cache.sv
module sim_lfc_cache;

  logic        clk;
  logic        rst_n;
  logic        cache_en;
  logic        cpu_req;
  logic        cpu_we;
  logic [2:0]  cpu_fc;
  logic [31:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req;
  logic        mem_burst;
  logic        mem_we;
  logic [2:0]  mem_fc;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int checks;
  int fails;

  lfc_cache u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cache_en  (cache_en),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_fc    (cpu_fc),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_burst (mem_burst),
    .mem_we    (mem_we),
    .mem_fc    (mem_fc),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- memory model ----------------
  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction

  logic [31:0] bmem [4096];
  logic        slow;
  logic        stall_q;
  int          beats;
  int          singles;
  logic [31:0] blog [4];
  int          bptr;

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = pat(32'(i) << 2);
  end

  assign mem_ack   = mem_req && !(slow && stall_q);
  assign mem_rdata = bmem[mem_addr[13:2]];

  always @(posedge clk) begin
    stall_q <= !stall_q;
    if (mem_req && mem_ack) begin
      if (mem_burst) begin
        beats <= beats + 1;
        blog[bptr % 4] <= mem_addr;
        bptr <= bptr + 1;
      end else begin
        singles <= singles + 1;
      end
      if (mem_we) bmem[mem_addr[13:2]] <= mem_wdata;
    end
  end

  // ---------------- watchdog ----------------
  int cyc;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog R1..R12 run did not finish actual=%0d expected<%0d", cyc, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] fc, input logic [31:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_fc    = fc;
    cpu_addr  = addr;
    cpu_wdata = wd;
    #1;
    while (!cpu_ack) begin
      @(negedge clk);
      #1;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        we;
    logic [2:0]  fc;
    logic [31:0] addr;
    logic [31:0] data;     // write data, or expected read data when use_data
    logic        use_data;
    logic [2:0]  nbeats;   // expected burst beats
    logic [1:0]  nsingle;  // expected single accesses
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd1, 32'h0000_1024, 32'h0,          1'b0, 3'd4, 2'd0}, // R1 R2 R3 first miss
    '{1'b0, 3'd1, 32'h0000_1028, 32'h0,          1'b0, 3'd0, 2'd0}, // R4 hit word 2
    '{1'b0, 3'd1, 32'h0000_1020, 32'h0,          1'b0, 3'd0, 2'd0}, // R4 hit word 0
    '{1'b0, 3'd1, 32'h0000_102C, 32'h0,          1'b0, 3'd0, 2'd0}, // R4 hit word 3
    '{1'b0, 3'd5, 32'h0000_1024, 32'h0,          1'b0, 3'd4, 2'd0}, // R5 other fc misses
    '{1'b0, 3'd5, 32'h0000_1024, 32'h0,          1'b0, 3'd0, 2'd0}, // R5 now hits
    '{1'b0, 3'd1, 32'h0000_1024, 32'h0,          1'b0, 3'd4, 2'd0}, // R5 user copy evicted
    '{1'b0, 3'd1, 32'h0000_1124, 32'h0,          1'b0, 3'd4, 2'd0}, // R6 conflict
    '{1'b0, 3'd1, 32'h0000_1024, 32'h0,          1'b0, 3'd4, 2'd0}, // R6 thrash back
    '{1'b1, 3'd1, 32'h0000_1028, 32'hDEAD_BEEF,  1'b0, 3'd0, 2'd1}, // R7 R8 write hit
    '{1'b0, 3'd1, 32'h0000_1028, 32'hDEAD_BEEF,  1'b1, 3'd0, 2'd0}, // R8 read updated word
    '{1'b1, 3'd1, 32'h0000_2040, 32'h1234_5678,  1'b0, 3'd0, 2'd1}, // R7 R9 write miss
    '{1'b0, 3'd1, 32'h0000_2040, 32'h1234_5678,  1'b1, 3'd4, 2'd0}, // R9 no allocate
    '{1'b0, 3'd1, 32'h0000_2040, 32'h1234_5678,  1'b1, 3'd0, 2'd0}  // R4 hit after fill
  };

  initial begin
    logic [31:0] rd;
    int b0, s0;
    checks   = 0;
    fails    = 0;
    cyc      = 0;
    beats    = 0;
    singles  = 0;
    bptr     = 0;
    stall_q  = 1'b0;
    slow     = 1'b0;
    rst_n    = 1'b0;
    cache_en = 1'b1;
    cpu_req  = 1'b0;
    cpu_we   = 1'b0;
    cpu_fc   = 3'd0;
    cpu_addr = '0;
    cpu_wdata = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 cpu_ack in reset", {31'b0, cpu_ack}, 32'd0);
    chk("R1 mem_req in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mem_req idle after reset", {31'b0, mem_req}, 32'd0);

    // table walk, with a memory that stalls every other cycle (R12)
    slow = 1'b1;
    for (int v = 0; v < NV; v++) begin
      b0 = beats;
      s0 = singles;
      access(VECS[v].we, VECS[v].fc, VECS[v].addr, VECS[v].data, rd);
      if (!VECS[v].we) begin
        chk($sformatf("R3 R4 R8 vec%0d read data", v), rd,
            VECS[v].use_data ? VECS[v].data : pat(VECS[v].addr));
      end
      chk($sformatf("R2 R4 R5 R6 R9 vec%0d burst beats", v), 32'(beats - b0),
          32'(VECS[v].nbeats));
      chk($sformatf("R7 vec%0d single accesses", v), 32'(singles - s0),
          32'(VECS[v].nsingle));
      if (v == 0) begin
        for (int k = 0; k < 4; k++) begin
          chk($sformatf("R2 beat %0d address", k), blog[k], 32'h0000_1020 + 32'(4 * k));
        end
      end
    end
    slow = 1'b0;

    // R10: disabled cache bypasses, reads come from memory, no bursts
    @(negedge clk);
    cache_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      b0 = beats;
      s0 = singles;
      access(1'b0, 3'd1, 32'h0000_2040, 32'h0, rd);
      chk("R10 off read data", rd, 32'h1234_5678);
      chk("R10 off read single", 32'(singles - s0), 32'd1);
      chk("R10 off read no burst", 32'(beats - b0), 32'd0);
    end
    b0 = beats;
    s0 = singles;
    access(1'b1, 3'd1, 32'h0000_2044, 32'hCAFE_0001, rd);
    chk("R10 R7 off write single", 32'(singles - s0), 32'd1);
    chk("R10 off write no burst", 32'(beats - b0), 32'd0);

    // R11: re-enable; the line at index 4 was resident before and must miss
    @(negedge clk);
    cache_en = 1'b1;
    @(negedge clk);
    b0 = beats;
    access(1'b0, 3'd1, 32'h0000_2044, 32'h0, rd);
    chk("R11 miss after re-enable", 32'(beats - b0), 32'd4);
    chk("R11 R3 data after refill", rd, 32'hCAFE_0001);

    // R4: hit is acknowledged in the request cycle with no memory request
    @(negedge clk);
    cpu_req  = 1'b1;
    cpu_we   = 1'b0;
    cpu_fc   = 3'd1;
    cpu_addr = 32'h0000_2040;
    #1;
    chk("R4 same-cycle ack", {31'b0, cpu_ack}, 32'd1);
    chk("R4 no mem_req on hit", {31'b0, mem_req}, 32'd0);
    chk("R4 hit data", cpu_rdata, 32'h1234_5678);
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
    repeat (2) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule